// File: doc/BRIEF.md
# Exclusive Access Reservation Monitor

This block sits beside a memory port on the slave side and decides the outcome of exclusive read-modify-write sequences. It observes each accepted read-address event and each accepted write-address event. Every event carries a requester ID, a start address, a size code, a length code, cache attribute bits and an exclusive flag. A legal exclusive read places a reservation on the byte range it covers, keyed by its ID. A later exclusive write with the same ID, start address and byte count succeeds only if that reservation is still intact. Any write that actually reaches memory and overlaps a reserved range destroys the reservation.

For each write the block returns a pass/fail verdict, a write-enable permit for the memory array and a response code. For each read it returns a response code. Response code 2'b00 means plain okay and 2'b01 means exclusive okay. All results are registered and appear on the clock edge after the one that accepts the event. The reservation table has a fixed number of slots. A read whose ID has no live slot takes the slot at a rotating pointer, which is the slot allocated longest ago.

Top module: `xmon_top`

## Requirements
- R1: After reset the table is empty, so an exclusive write fails. `rdRespValid`, `wrRespValid`, `wrEnable` and `wrPass` are 0 while no response is due.
- R2: An exclusive read that is legal answers 2'b01 and records a reservation one cycle after acceptance. A non-exclusive read answers 2'b00 and records nothing.
- R3: An exclusive write whose ID, start address and byte count equal a live reservation passes. It shows `wrPass`=1, `wrEnable`=1 and response 2'b01 one cycle later, and it consumes the reservation, so an identical repeat fails.
- R4: A failing exclusive write gives response 2'b00 with `wrEnable`=0 and `wrPass`=0. Memory is left unchanged and no reservation is cleared.
- R5: A newer legal exclusive read with an ID that already holds a reservation moves that reservation to the new range. An exclusive write to the old range then fails.
- R6: Any write with `wrEnable`=1 whose byte range [addr, addr+bytes) overlaps a reserved range clears that reservation. A write that does not overlap leaves it intact.
- R7: The byte count is (length code + 1) << size code. An exclusive access is legal only if this count is a power of two no greater than 128. An illegal exclusive read answers 2'b00 and records nothing. An illegal exclusive write fails.
- R8: An exclusive access whose start address is not a multiple of its byte count is illegal. The read answers 2'b00 and the write fails.
- R9: An exclusive access whose cache attribute has any of bits 3..1 set is treated as cacheable and fails. The read answers 2'b00 and records nothing. The write fails.
- R10: The table holds 4 reservations. A legal exclusive read whose ID owns no live slot overwrites the slot allocated longest ago, so with four live IDs a fifth ID evicts the first.
- R11: When a read and a write are accepted in the same cycle, the write is judged and its clearing applied against the table as it stood before that cycle. The read's new reservation is installed afterwards and survives.
- R12: A non-exclusive write always has `wrEnable`=1, `wrPass`=0 and response 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rdValid | input | 1 | A read-address event is accepted this cycle |
| rdId | input | ID_W | Read requester ID |
| rdAddr | input | ADDR_W | Read start address |
| rdSize | input | 3 | Read size code (bytes per beat = 2^code) |
| rdLen | input | 4 | Read length code (beats = code + 1) |
| rdCache | input | 4 | Read cache attribute bits |
| rdExcl | input | 1 | Read is exclusive |
| wrValid | input | 1 | A write-address event is accepted this cycle |
| wrId | input | ID_W | Write requester ID |
| wrAddr | input | ADDR_W | Write start address |
| wrSize | input | 3 | Write size code |
| wrLen | input | 4 | Write length code |
| wrCache | input | 4 | Write cache attribute bits |
| wrExcl | input | 1 | Write is exclusive |
| rdRespValid | output | 1 | Read response due |
| rdResp | output | 2 | Read response code |
| wrRespValid | output | 1 | Write verdict due |
| wrResp | output | 2 | Write response code |
| wrPass | output | 1 | Exclusive write succeeded |
| wrEnable | output | 1 | Permit to update memory |

## Verification
Every result is due exactly one cycle after its event: the event is accepted on a rising edge and the registered verdict appears on that same edge for the next cycle. The bench presents each event on a falling edge and removes it on the following falling edge. It reads the outputs at that second falling edge, half a cycle after they change. Table effects are observed one event later, through the verdict of a follow-up write. The same-cycle case drives both events between the same pair of falling edges and checks both verdicts together.

// File: rtl/xmon_pkg.sv
package xmon_pkg;
  localparam logic [1:0] RESP_OKAY   = 2'b00;
  localparam logic [1:0] RESP_EXOKAY = 2'b01;
  localparam int unsigned MAX_EXCL_BYTES = 128;

  // strobes from control to the reservation table
  typedef struct packed {
    logic recordRd;  // install / move reservation for the read ID
    logic clearWr;   // drop reservations overlapped by the write
  } tblCtl_t;

  function automatic logic [11:0] xferBytes(input logic [2:0] sz, input logic [3:0] ln);
    return ({8'd0, ln} + 12'd1) << sz;
  endfunction

  function automatic logic isCacheable(input logic [3:0] attr);
    return attr[3:1] != 3'b000;
  endfunction
endpackage

// File: rtl/xmon_table.sv
module xmon_table
  import xmon_pkg::*;
#(
  parameter int ID_W   = 4,
  parameter int ADDR_W = 16,
  parameter int SLOTS  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  tblCtl_t           ctl,
  input  logic [ID_W-1:0]   rdId,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [7:0]        rdBytes,
  input  logic [ID_W-1:0]   wrId,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [11:0]       wrBytes,
  output logic              wrMatch
);
  localparam int PW = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  logic              vld    [SLOTS];
  logic [ID_W-1:0]   tId    [SLOTS];
  logic [ADDR_W-1:0] tBase  [SLOTS];
  logic [7:0]        tBytes [SLOTS];

  logic [SLOTS-1:0] rdHit, wrHit, overlap;
  logic [PW-1:0]    allocPtr, hitIdx, selIdx;
  logic [ADDR_W:0]  wrEnd;

  assign wrEnd = {1'b0, wrAddr} + (ADDR_W+1)'(wrBytes);

  for (genvar g = 0; g < SLOTS; g++) begin : gSlot
    logic [ADDR_W:0] slotEnd;
    assign slotEnd    = {1'b0, tBase[g]} + (ADDR_W+1)'(tBytes[g]);
    assign rdHit[g]   = vld[g] && (tId[g] == rdId);
    assign wrHit[g]   = vld[g] && (tId[g] == wrId) && (tBase[g] == wrAddr)
                        && ({4'd0, tBytes[g]} == wrBytes);
    assign overlap[g] = vld[g] && ({1'b0, wrAddr} < slotEnd)
                        && ({1'b0, tBase[g]} < wrEnd);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        vld[g]    <= 1'b0;
        tId[g]    <= '0;
        tBase[g]  <= '0;
        tBytes[g] <= '0;
      end else if (ctl.recordRd && (selIdx == PW'(g))) begin
        vld[g]    <= 1'b1;
        tId[g]    <= rdId;
        tBase[g]  <= rdAddr;
        tBytes[g] <= rdBytes;
      end else if (ctl.clearWr && overlap[g]) begin
        vld[g]    <= 1'b0;
      end
    end
  end

  always_comb begin
    hitIdx = '0;
    for (int i = 0; i < SLOTS; i++)
      if (rdHit[i]) hitIdx = PW'(i);
  end

  assign selIdx  = (|rdHit) ? hitIdx : allocPtr;
  assign wrMatch = |wrHit;

  always_ff @(posedge clk) begin
    if (!rstN)
      allocPtr <= '0;
    else if (ctl.recordRd && !(|rdHit))
      allocPtr <= (allocPtr == PW'(SLOTS-1)) ? '0 : allocPtr + 1'b1;
  end
endmodule

// File: rtl/xmon_ctrl.sv
module xmon_ctrl
  import xmon_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdValid,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [2:0]        rdSize,
  input  logic [3:0]        rdLen,
  input  logic [3:0]        rdCache,
  input  logic              rdExcl,
  input  logic              wrValid,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [2:0]        wrSize,
  input  logic [3:0]        wrLen,
  input  logic [3:0]        wrCache,
  input  logic              wrExcl,
  input  logic              wrMatch,
  output tblCtl_t           ctl,
  output logic [7:0]        rdBytes,
  output logic [11:0]       wrBytes,
  output logic              rdRespValid,
  output logic [1:0]        rdResp,
  output logic              wrRespValid,
  output logic [1:0]        wrResp,
  output logic              wrPass,
  output logic              wrEnable
);
  logic [11:0] rdCount;
  logic        rdLegal, wrLegal, wrOk, wrEn;

  assign rdCount = xferBytes(rdSize, rdLen);
  assign wrBytes = xferBytes(wrSize, wrLen);
  assign rdBytes = rdCount[7:0];

  assign rdLegal = rdExcl && ($countones(rdCount) == 1)
                   && (rdCount <= 12'(MAX_EXCL_BYTES))
                   && ((rdAddr & ADDR_W'(rdCount - 12'd1)) == '0)
                   && !isCacheable(rdCache);
  assign wrLegal = ($countones(wrBytes) == 1)
                   && (wrBytes <= 12'(MAX_EXCL_BYTES))
                   && ((wrAddr & ADDR_W'(wrBytes - 12'd1)) == '0)
                   && !isCacheable(wrCache);

  assign wrOk = wrValid && wrExcl && wrLegal && wrMatch;
  assign wrEn = wrValid && (!wrExcl || wrOk);

  assign ctl.recordRd = rdValid && rdLegal;
  assign ctl.clearWr  = wrEn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdRespValid <= 1'b0;
      rdResp      <= RESP_OKAY;
      wrRespValid <= 1'b0;
      wrResp      <= RESP_OKAY;
      wrPass      <= 1'b0;
      wrEnable    <= 1'b0;
    end else begin
      rdRespValid <= rdValid;
      rdResp      <= (rdValid && rdLegal) ? RESP_EXOKAY : RESP_OKAY;
      wrRespValid <= wrValid;
      wrResp      <= wrOk ? RESP_EXOKAY : RESP_OKAY;
      wrPass      <= wrOk;
      wrEnable    <= wrEn;
    end
  end
endmodule

// File: rtl/xmon_top.sv
module xmon_top
  import xmon_pkg::*;
#(
  parameter int ID_W   = 4,
  parameter int ADDR_W = 16,
  parameter int SLOTS  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdValid,
  input  logic [ID_W-1:0]   rdId,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [2:0]        rdSize,
  input  logic [3:0]        rdLen,
  input  logic [3:0]        rdCache,
  input  logic              rdExcl,
  input  logic              wrValid,
  input  logic [ID_W-1:0]   wrId,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [2:0]        wrSize,
  input  logic [3:0]        wrLen,
  input  logic [3:0]        wrCache,
  input  logic              wrExcl,
  output logic              rdRespValid,
  output logic [1:0]        rdResp,
  output logic              wrRespValid,
  output logic [1:0]        wrResp,
  output logic              wrPass,
  output logic              wrEnable
);
  tblCtl_t     ctl;
  logic        wrMatch;
  logic [7:0]  rdBytes;
  logic [11:0] wrBytes;

  xmon_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .rdValid(rdValid), .rdAddr(rdAddr), .rdSize(rdSize), .rdLen(rdLen),
    .rdCache(rdCache), .rdExcl(rdExcl),
    .wrValid(wrValid), .wrAddr(wrAddr), .wrSize(wrSize), .wrLen(wrLen),
    .wrCache(wrCache), .wrExcl(wrExcl),
    .wrMatch(wrMatch), .ctl(ctl), .rdBytes(rdBytes), .wrBytes(wrBytes),
    .rdRespValid(rdRespValid), .rdResp(rdResp),
    .wrRespValid(wrRespValid), .wrResp(wrResp),
    .wrPass(wrPass), .wrEnable(wrEnable)
  );

  xmon_table #(.ID_W(ID_W), .ADDR_W(ADDR_W), .SLOTS(SLOTS)) table_i (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .rdId(rdId), .rdAddr(rdAddr), .rdBytes(rdBytes),
    .wrId(wrId), .wrAddr(wrAddr), .wrBytes(wrBytes),
    .wrMatch(wrMatch)
  );
endmodule

// File: rtl/xmon_chk.sv
module xmon_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              rdValid,
  input logic [3:0]        rdCache,
  input logic              rdExcl,
  input logic              wrValid,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [2:0]        wrSize,
  input logic [3:0]        wrCache,
  input logic              wrExcl,
  input logic              rdRespValid,
  input logic [1:0]        rdResp,
  input logic              wrRespValid,
  input logic [1:0]        wrResp,
  input logic              wrPass,
  input logic              wrEnable
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !wrRespValid |-> (!wrEnable && !wrPass)); // R1
  AST_PLAIN_READ_OKAY: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && !rdExcl) |=> (rdRespValid && rdResp == 2'b00)); // R2
  AST_PASS_EXOKAY: assert property (@(posedge clk) disable iff (!rstN)
    (wrRespValid && wrPass) |-> (wrResp == 2'b01 && wrEnable)); // R3
  AST_OKAY_NO_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (wrRespValid && wrResp == 2'b00) |-> !wrPass); // R4
  AST_UNALIGNED_FAILS: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && wrExcl && wrAddr[0] && wrSize != 3'd0) |=> (!wrPass && !wrEnable)); // R8
  AST_CACHEABLE_WR_FAILS: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && wrExcl && wrCache[3:1] != 3'b000) |=> (!wrPass && !wrEnable)); // R9
  AST_CACHEABLE_RD_OKAY: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && rdExcl && rdCache[3:1] != 3'b000) |=> (rdResp == 2'b00)); // R9
  AST_PLAIN_WRITE_ENABLED: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && !wrExcl) |=> (wrEnable && !wrPass && wrResp == 2'b00)); // R12
endmodule

bind xmon_top xmon_chk #(.ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/xmon_top_tb_top.sv
`timescale 1ns/1ps
module xmon_top_tb_top;
  typedef struct packed {
    logic        isWr;
    logic [3:0]  id;
    logic [15:0] addr;
    logic [2:0]  size;
    logic [3:0]  len;
    logic [3:0]  cache;
    logic        excl;
    logic [1:0]  eResp;
    logic        eWen;
    logic        ePass;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 29;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 4'd1,  16'h0100, 3'd2, 4'd0,  4'd0, 1'b1, 2'd1, 1'b0, 1'b0, 4'd2},  // R2 legal excl read
    '{1'b1, 4'd1,  16'h0100, 3'd2, 4'd0,  4'd0, 1'b1, 2'd1, 1'b1, 1'b1, 4'd3},  // R3 pass
    '{1'b1, 4'd1,  16'h0100, 3'd2, 4'd0,  4'd0, 1'b1, 2'd0, 1'b0, 1'b0, 4'd4},  // R4 consumed
    '{1'b0, 4'd2,  16'h0200, 3'd2, 4'd0,  4'd0, 1'b0, 2'd0, 1'b0, 1'b0, 4'd2},  // R2 plain read
    '{1'b1, 4'd2,  16'h0200, 3'd2, 4'd0,  4'd0, 1'b1, 2'd0, 1'b0, 1'b0, 4'd2},  // R2 nothing recorded
    '{1'b0, 4'd3,  16'h0300, 3'd2, 4'd0,  4'd0, 1'b1, 2'd1, 1'b0, 1'b0, 4'd5},  // R5
    '{1'b0, 4'd3,  16'h0340, 3'd2, 4'd0,  4'd0, 1'b1, 2'd1, 1'b0, 1'b0, 4'd5},  // R5 move
    '{1'b1, 4'd3,  16'h0300, 3'd2, 4'd0,  4'd0, 1'b1, 2'd0, 1'b0, 1'b0, 4'd5},  // R5 old range fails
    '{1'b1, 4'd3,  16'h0340, 3'd2, 4'd0,  4'd0, 1'b1, 2'd1, 1'b1, 1'b1, 4'd5},  // R5 new range passes
    '{1'b0, 4'd4,  16'h0400, 3'd3, 4'd0,  4'd0, 1'b1, 2'd1, 1'b0, 1'b0, 4'd6},  // R6
    '{1'b1, 4'd9,  16'h0404, 3'd0, 4'd0,  4'd0, 1'b0, 2'd0, 1'b1, 1'b0, 4'd12}, // R12 plain, overlaps
    '{1'b1, 4'd4,  16'h0400, 3'd3, 4'd0,  4'd0, 1'b1, 2'd0, 1'b0, 1'b0, 4'd6},  // R6 cleared
    '{1'b0, 4'd5,  16'h0500, 3'd2, 4'd0,  4'd0, 1'b1, 2'd1, 1'b0, 1'b0, 4'd6},  // R6
    '{1'b1, 4'd9,  16'h0504, 3'd2, 4'd0,  4'd0, 1'b0, 2'd0, 1'b1, 1'b0, 4'd6},  // R6 adjacent, no overlap
    '{1'b1, 4'd5,  16'h0500, 3'd2, 4'd0,  4'd0, 1'b1, 2'd1, 1'b1, 1'b1, 4'd6},  // R6 intact
    '{1'b0, 4'd6,  16'h0600, 3'd2, 4'd2,  4'd0, 1'b1, 2'd0, 1'b0, 1'b0, 4'd7},  // R7 12 bytes
    '{1'b1, 4'd6,  16'h0600, 3'd2, 4'd2,  4'd0, 1'b1, 2'd0, 1'b0, 1'b0, 4'd7},  // R7
    '{1'b0, 4'd6,  16'h0600, 3'd3, 4'd1,  4'd0, 1'b1, 2'd1, 1'b0, 1'b0, 4'd7},  // R7 16 bytes
    '{1'b1, 4'd6,  16'h0600, 3'd3, 4'd1,  4'd0, 1'b1, 2'd1, 1'b1, 1'b1, 4'd7},  // R7
    '{1'b0, 4'd7,  16'h0600, 3'd2, 4'd15, 4'd0, 1'b1, 2'd1, 1'b0, 1'b0, 4'd7},  // R7 64 bytes
    '{1'b1, 4'd7,  16'h0600, 3'd2, 4'd15, 4'd0, 1'b1, 2'd1, 1'b1, 1'b1, 4'd7},  // R7
    '{1'b0, 4'd7,  16'h0000, 3'd7, 4'd1,  4'd0, 1'b1, 2'd0, 1'b0, 1'b0, 4'd7},  // R7 256 bytes
    '{1'b0, 4'd8,  16'h0704, 3'd3, 4'd0,  4'd0, 1'b1, 2'd0, 1'b0, 1'b0, 4'd8},  // R8 unaligned
    '{1'b1, 4'd8,  16'h0704, 3'd3, 4'd0,  4'd0, 1'b1, 2'd0, 1'b0, 1'b0, 4'd8},  // R8
    '{1'b0, 4'd8,  16'h0708, 3'd3, 4'd0,  4'd0, 1'b1, 2'd1, 1'b0, 1'b0, 4'd8},  // R8 aligned
    '{1'b1, 4'd8,  16'h0708, 3'd3, 4'd0,  4'd2, 1'b1, 2'd0, 1'b0, 1'b0, 4'd9},  // R9 cacheable write
    '{1'b1, 4'd8,  16'h0708, 3'd3, 4'd0,  4'd0, 1'b1, 2'd1, 1'b1, 1'b1, 4'd9},  // R9 survived
    '{1'b0, 4'd10, 16'h0800, 3'd2, 4'd0,  4'd2, 1'b1, 2'd0, 1'b0, 1'b0, 4'd9},  // R9 cacheable read
    '{1'b1, 4'd10, 16'h0800, 3'd2, 4'd0,  4'd0, 1'b1, 2'd0, 1'b0, 1'b0, 4'd9}   // R9 not recorded
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rdValid = 0, rdExcl = 0, wrValid = 0, wrExcl = 0;
  logic [3:0] rdId = 0, wrId = 0, rdLen = 0, wrLen = 0, rdCache = 0, wrCache = 0;
  logic [15:0] rdAddr = 0, wrAddr = 0;
  logic [2:0] rdSize = 0, wrSize = 0;
  logic rdRespValid, wrRespValid, wrPass, wrEnable;
  logic [1:0] rdResp, wrResp;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  xmon_top dut_i (.*);

  task automatic check(input bit ok, input string what, input int req,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic setRd(input logic [3:0] id, input logic [15:0] a, input logic [2:0] s,
                       input logic [3:0] l, input logic [3:0] c, input logic x);
    rdValid = 1; rdId = id; rdAddr = a; rdSize = s; rdLen = l; rdCache = c; rdExcl = x;
  endtask

  task automatic setWr(input logic [3:0] id, input logic [15:0] a, input logic [2:0] s,
                       input logic [3:0] l, input logic [3:0] c, input logic x);
    wrValid = 1; wrId = id; wrAddr = a; wrSize = s; wrLen = l; wrCache = c; wrExcl = x;
  endtask

  // events were set after a falling edge; release at the next one, results now stable
  task automatic step();
    @(negedge clk);
    rdValid = 0; wrValid = 0;
  endtask

  task automatic expRd(input logic [1:0] e, input int req);
    check(rdRespValid === 1'b1, "rdRespValid", req, rdRespValid, 1);
    check(rdResp === e, "rdResp", req, rdResp, e);
  endtask

  task automatic expWr(input logic [1:0] e, input logic wen, input logic pass, input int req);
    check(wrRespValid === 1'b1, "wrRespValid", req, wrRespValid, 1);
    check(wrResp === e, "wrResp", req, wrResp, e);
    check(wrEnable === wen, "wrEnable", req, wrEnable, wen);
    check(wrPass === pass, "wrPass", req, wrPass, pass);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 0; rdValid = 0; wrValid = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
  endtask

  initial begin
    #(4 * 20000);
    checks++; fails++;
    $display("FAIL watchdog expired, run hung");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    doReset();
    // R1: quiet outputs, empty table
    check(rdRespValid === 0 && wrRespValid === 0, "idle valids R1", 1,
          {rdRespValid, wrRespValid}, 0);
    check(wrEnable === 0 && wrPass === 0, "idle wen/pass R1", 1, {wrEnable, wrPass}, 0);
    setWr(4'd1, 16'h0100, 3'd2, 4'd0, 4'd0, 1'b1); step();
    expWr(2'd0, 1'b0, 1'b0, 1); // R1 nothing reserved
    @(negedge clk);
    check(wrRespValid === 0, "response one cycle only R1", 1, wrRespValid, 0);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].isWr) begin
        setWr(VECS[i].id, VECS[i].addr, VECS[i].size, VECS[i].len, VECS[i].cache, VECS[i].excl);
        step();
        expWr(VECS[i].eResp, VECS[i].eWen, VECS[i].ePass, int'(VECS[i].req));
      end else begin
        setRd(VECS[i].id, VECS[i].addr, VECS[i].size, VECS[i].len, VECS[i].cache, VECS[i].excl);
        step();
        expRd(VECS[i].eResp, int'(VECS[i].req));
      end
    end

    // R10: fifth ID evicts the oldest slot
    doReset();
    for (int k = 1; k <= 5; k++) begin
      setRd(4'(k), 16'(k * 256), 3'd2, 4'd0, 4'd0, 1'b1); step();
      expRd(2'd1, 10);
    end
    setWr(4'd1, 16'h0100, 3'd2, 4'd0, 4'd0, 1'b1); step();
    expWr(2'd0, 1'b0, 1'b0, 10); // R10 evicted
    setWr(4'd2, 16'h0200, 3'd2, 4'd0, 4'd0, 1'b1); step();
    expWr(2'd1, 1'b1, 1'b1, 10); // R10 kept
    setWr(4'd5, 16'h0500, 3'd2, 4'd0, 4'd0, 1'b1); step();
    expWr(2'd1, 1'b1, 1'b1, 10); // R10 newest

    // R11: same-cycle ordering
    doReset();
    setRd(4'd1, 16'h0100, 3'd2, 4'd0, 4'd0, 1'b1); step();
    expRd(2'd1, 11);
    setRd(4'd1, 16'h0100, 3'd2, 4'd0, 4'd0, 1'b1);
    setWr(4'd9, 16'h0100, 3'd2, 4'd0, 4'd0, 1'b0); step();
    expRd(2'd1, 11);
    expWr(2'd0, 1'b1, 1'b0, 11);
    setWr(4'd1, 16'h0100, 3'd2, 4'd0, 4'd0, 1'b1); step();
    expWr(2'd1, 1'b1, 1'b1, 11); // R11 reinstalled read survived the plain write
    setRd(4'd2, 16'h0200, 3'd2, 4'd0, 4'd0, 1'b1); step();
    expRd(2'd1, 11);
    setRd(4'd2, 16'h0240, 3'd2, 4'd0, 4'd0, 1'b1);
    setWr(4'd2, 16'h0200, 3'd2, 4'd0, 4'd0, 1'b1); step();
    expRd(2'd1, 11);
    expWr(2'd1, 1'b1, 1'b1, 11); // R11 judged on old table
    setWr(4'd2, 16'h0240, 3'd2, 4'd0, 4'd0, 1'b1); step();
    expWr(2'd1, 1'b1, 1'b1, 11); // R11 moved reservation installed

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule